// File: doc/BRIEF.md
# Dual Gated Timer/Counter

This block holds two general-purpose timer/counters behind a small byte-wide register bus. Each channel advances either on a prescaled system tick or on falling edges seen on its own count pin. A run bit enables each channel, and an external gate pin can also be made to control it. A channel can be a 13-bit counter, a 16-bit counter or an 8-bit counter that reloads itself. Channel 0 can also split into two independent 8-bit counters. When a channel wraps, it sets a sticky overflow flag, and that flag drives the channel's interrupt request line.

Software sets up the channels by writing the mode, control and clock-select registers, and it preloads or reads the four count bytes. The interrupt requests go to an outside controller. That controller can clear a flag with a one-cycle acknowledge pulse, or software can clear it by writing zero.

Top module: `dual_timer_core`

## Requirements
- R1: Register addresses are 0 mode, 1 control, 2 clock select, 3 channel-0 low byte, 4 channel-0 high byte, 5 channel-1 low byte and 6 channel-1 high byte. Address 7 reads 0. Every register reads 0 after reset, and both interrupt lines are low.
- R2: The mode register carries channel 0 in bits 3:0 and channel 1 in bits 7:4. Within each nibble, bit 3 is the gate enable, bit 2 selects pin counting, and bits 1:0 select the mode (0 13-bit, 1 16-bit, 2 reload, 3 split). In mode 1 the high:low bytes form one 16-bit up-counter, and wrapping from FFFFh to 0000h sets the flag.
- R3: In mode 0, only low bits 4:0 count, and their carry feeds the high byte. Low bits 7:5 keep their written value. Stepping from high=FFh, low[4:0]=1Fh gives zero and sets the flag.
- R4: In mode 2, the low byte counts. On stepping from FFh it loads the high byte and sets the flag.
- R5: When channel 0 is in mode 3, its low byte counts as an 8-bit counter under channel 0's controls and flag. Its high byte counts channel 0's prescaled ticks while channel 1's run bit is set, and it sets channel 1's flag. Channel 1 holds its count in this case, and also whenever its own mode is 3.
- R6: A channel advances only when its run bit is 1 and either its gate enable is 0 or its gate pin (after a 2-flop synchronizer) is high.
- R7: With pin counting selected, a falling edge on the synchronized count pin is remembered until the next prescaled tick. Each tick adds at most one count.
- R8: Clock select bits 0 and 1 pick divide-by-4 for channels 0 and 1. Bits 2 and 3 pick divide-by-1 and take priority over divide-by-4. With neither bit set, the channel uses divide-by-12.
- R9: The control register has channel-0 run at bit 4 and flag at bit 5, and channel-1 run at bit 6 and flag at bit 7. A flag clears on a control write of 0 or on its acknowledge pulse. An overflow in the same cycle wins over the clear. The interrupt lines mirror the flags.
- R10: A write to either count byte of a channel in a cycle replaces that byte and suppresses that channel's step in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the current address (combinational) |
| cnt_pin_i | input | 2 | External count pins, one per channel |
| gate_pin_i | input | 2 | External gate pins, one per channel |
| irq_ack_i | input | 2 | Interrupt acknowledge pulses, one per channel |
| irq_o | output | 2 | Interrupt requests (overflow flags) |

## Verification
A register write takes effect at the clock edge that samples it, and read data reflects the new value in the cycle after. Counts and flags change at the edge of the qualifying tick. A falling count-pin edge becomes countable two edges after the pin changes, and a gate change takes effect two edges after the pin changes. The bench drives every input 1 ns after a rising edge and samples at the falling edge. A behavioural model steps on each rising edge with the same inputs, and the bench compares read data and interrupt lines at every falling edge. Directed windows span whole multiples of 12 ticks, so the exact counts they expect do not depend on the prescaler phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NTMR      = 2;
  localparam int DATA_W    = 8;
  localparam int LOW13_W   = 5;
  localparam int SLOW_DIV  = 12;
  localparam int FAST_DIV  = 4;
  localparam int SYNC_STG  = 2;
  localparam int ADDR_W    = 3;

  typedef enum logic [1:0] {
    MODE_13B    = 2'd0,
    MODE_16B    = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } tmode_e;

  localparam logic [ADDR_W-1:0] ADR_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CKS  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CNT  = 3'd3;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV   = 12,
  parameter int QUART = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_slow_o,
  output logic tick_quart_o
);
  localparam int CW = $clog2(DIV);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d        = (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
    tick_slow_o  = (cnt_q == CW'(DIV - 1));
    tick_quart_o = ((cnt_q % CW'(QUART)) == CW'(QUART - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cnt_pin_i,
  input  logic [N-1:0] gate_pin_i,
  output logic [N-1:0] cnt_fall_o,
  output logic [N-1:0] gate_lvl_o
);
  logic [STAGES-1:0][N-1:0] cnt_sh_q, cnt_sh_d, gate_sh_q, gate_sh_d;
  logic [N-1:0] prev_q;

  always_comb begin
    cnt_sh_d   = {cnt_sh_q[STAGES-2:0], cnt_pin_i};
    gate_sh_d  = {gate_sh_q[STAGES-2:0], gate_pin_i};
    cnt_fall_o = prev_q & ~cnt_sh_q[STAGES-1];
    gate_lvl_o = gate_sh_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_sh_q  <= '0;
      gate_sh_q <= '0;
      prev_q    <= '0;
    end else begin
      cnt_sh_q  <= cnt_sh_d;
      gate_sh_q <= gate_sh_d;
      prev_q    <= cnt_sh_q[STAGES-1];
    end
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter bit SPLIT_OK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmode_e            mode_i,
  input  logic              inc_i,
  input  logic              hi_inc_i,
  input  logic              hold_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o,
  output logic              ovf_o,
  output logic              hi_ovf_o
);
  logic [DATA_W-1:0] lo_q, lo_d, hi_q, hi_d;

  always_comb begin
    lo_d     = lo_q;
    hi_d     = hi_q;
    ovf_o    = 1'b0;
    hi_ovf_o = 1'b0;
    if (wr_lo_i || wr_hi_i) begin
      if (wr_lo_i) lo_d = wdata_i;
      if (wr_hi_i) hi_d = wdata_i;
    end else if (!hold_i) begin
      unique case (mode_i)
        MODE_13B: if (inc_i) begin
          lo_d[LOW13_W-1:0] = lo_q[LOW13_W-1:0] + 1'b1;
          if (&lo_q[LOW13_W-1:0]) begin
            hi_d  = hi_q + 1'b1;
            ovf_o = &hi_q;
          end
        end
        MODE_16B: if (inc_i) begin
          {hi_d, lo_d} = {hi_q, lo_q} + 1'b1;
          ovf_o        = &{hi_q, lo_q};
        end
        MODE_RELOAD: if (inc_i) begin
          if (&lo_q) begin
            lo_d  = hi_q;
            ovf_o = 1'b1;
          end else begin
            lo_d = lo_q + 1'b1;
          end
        end
        default: if (SPLIT_OK) begin
          if (inc_i) begin
            lo_d  = lo_q + 1'b1;
            ovf_o = &lo_q;
          end
          if (hi_inc_i) begin
            hi_d     = hi_q + 1'b1;
            hi_ovf_o = &hi_q;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/dual_timer_core.sv
module dual_timer_core
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [NTMR-1:0]   cnt_pin_i,
  input  logic [NTMR-1:0]   gate_pin_i,
  input  logic [NTMR-1:0]   irq_ack_i,
  output logic [NTMR-1:0]   irq_o
);
  localparam int CKS_W = 2 * NTMR;

  logic rs1_q, rs2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  logic [DATA_W-1:0] mode_q, mode_d;
  logic [CKS_W-1:0]  cks_q, cks_d;
  logic [NTMR-1:0]   run_q, run_d, flag_q, flag_d, pend_q, pend_d;
  logic [NTMR-1:0]   tick, inc, hi_inc, hold, ovf, hovf, set, wr_lo, wr_hi;
  logic [NTMR-1:0]   cnt_fall, gate_lvl;
  logic [DATA_W-1:0] lo_w [NTMR];
  logic [DATA_W-1:0] hi_w [NTMR];
  logic tick_slow, tick_quart, wr_ctrl;

  tmr_prescale #(.DIV(SLOW_DIV), .QUART(FAST_DIV)) u_presc (
    .clk(clk), .rst_n(rs2_q), .tick_slow_o(tick_slow), .tick_quart_o(tick_quart)
  );

  tmr_pin_sync #(.N(NTMR), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rs2_q), .cnt_pin_i(cnt_pin_i), .gate_pin_i(gate_pin_i),
    .cnt_fall_o(cnt_fall), .gate_lvl_o(gate_lvl)
  );

  assign wr_ctrl = bus_wr_i && (bus_addr_i == ADR_CTRL);

  for (genvar i = 0; i < NTMR; i++) begin : g_ch
    tmode_e md;
    logic   gate_en, pin_mode;
    assign md       = tmode_e'(mode_q[4*i +: 2]);
    assign pin_mode = mode_q[4*i + 2];
    assign gate_en  = mode_q[4*i + 3];
    assign tick[i]  = cks_q[NTMR + i] ? 1'b1 : (cks_q[i] ? tick_quart : tick_slow);
    assign inc[i]   = run_q[i] && (!gate_en || gate_lvl[i]) && tick[i] &&
                      (!pin_mode || pend_q[i] || cnt_fall[i]);
    assign pend_d[i] = (pend_q[i] || cnt_fall[i]) && !tick[i];
    assign wr_lo[i] = bus_wr_i && (bus_addr_i == ADR_CNT + ADDR_W'(2*i));
    assign wr_hi[i] = bus_wr_i && (bus_addr_i == ADR_CNT + ADDR_W'(2*i + 1));
    assign run_d[i] = wr_ctrl ? bus_wdata_i[4 + 2*i] : run_q[i];
    assign flag_d[i] = set[i] || (wr_ctrl ? bus_wdata_i[5 + 2*i]
                                          : (flag_q[i] && !irq_ack_i[i]));

    tmr_unit #(.SPLIT_OK(i == 0)) u_unit (
      .clk(clk), .rst_n(rs2_q), .mode_i(md), .inc_i(inc[i]), .hi_inc_i(hi_inc[i]),
      .hold_i(hold[i]), .wr_lo_i(wr_lo[i]), .wr_hi_i(wr_hi[i]), .wdata_i(bus_wdata_i),
      .lo_o(lo_w[i]), .hi_o(hi_w[i]), .ovf_o(ovf[i]), .hi_ovf_o(hovf[i])
    );
  end

  always_comb begin
    hi_inc    = '0;
    hi_inc[0] = run_q[1] && tick[0];
    hold      = '0;
    hold[1]   = (tmode_e'(mode_q[1:0]) == MODE_SPLIT);
    set       = ovf;
    set[1]    = ovf[1] || (|hovf);
    mode_d    = (bus_wr_i && bus_addr_i == ADR_MODE) ? bus_wdata_i : mode_q;
    cks_d     = (bus_wr_i && bus_addr_i == ADR_CKS) ? bus_wdata_i[CKS_W-1:0] : cks_q;
  end

  always_ff @(posedge clk or negedge rs2_q) begin
    if (!rs2_q) begin
      mode_q <= '0;
      cks_q  <= '0;
      run_q  <= '0;
      flag_q <= '0;
      pend_q <= '0;
    end else begin
      mode_q <= mode_d;
      cks_q  <= cks_d;
      run_q  <= run_d;
      flag_q <= flag_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    unique case (bus_addr_i)
      3'd0:    bus_rdata_o = mode_q;
      3'd1:    bus_rdata_o = {flag_q[1], run_q[1], flag_q[0], run_q[0], 4'b0000};
      3'd2:    bus_rdata_o = {{(DATA_W-CKS_W){1'b0}}, cks_q};
      3'd3:    bus_rdata_o = lo_w[0];
      3'd4:    bus_rdata_o = hi_w[0];
      3'd5:    bus_rdata_o = lo_w[1];
      3'd6:    bus_rdata_o = hi_w[1];
      default: bus_rdata_o = '0;
    endcase
  end

  assign irq_o = flag_q;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr_i,
  input logic [2:0] bus_addr_i,
  input logic       ack0,
  input logic [1:0] msel0,
  input logic       mgate0,
  input logic       run0,
  input logic       flag0,
  input logic       inc0,
  input logic       ovf0,
  input logic       glvl0,
  input logic [7:0] lo0,
  input logic [7:0] hi0,
  input logic [7:0] lo1,
  input logic [7:0] hi1
);
  logic wr_t0, wr_t1, wr_c;
  assign wr_t0 = bus_wr_i && (bus_addr_i == 3'd3 || bus_addr_i == 3'd4);
  assign wr_t1 = bus_wr_i && (bus_addr_i == 3'd5 || bus_addr_i == 3'd6);
  assign wr_c  = bus_wr_i && (bus_addr_i == 3'd1);

  // R6
  gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mgate0 && !glvl0) |-> !inc0);

  // R6
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run0 && !wr_t0 && msel0 != 2'd3) |=> ($stable(lo0) && $stable(hi0)));

  // R3
  wrap13_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msel0 == 2'd0 && inc0 && lo0[4:0] == 5'h1F && hi0 == 8'hFF && !wr_t0)
    |=> (hi0 == 8'h00 && lo0[4:0] == 5'h00 && flag0));

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msel0 == 2'd2 && inc0 && lo0 == 8'hFF && !wr_t0)
    |=> (lo0 == $past(hi0) && flag0));

  // R5
  split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msel0 == 2'd3 && !wr_t1) |=> ($stable(lo1) && $stable(hi1)));

  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack0 && !ovf0 && !wr_c) |=> !flag0);
endmodule

bind dual_timer_core tmr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
  .ack0(irq_ack_i[0]), .msel0(mode_q[1:0]), .mgate0(mode_q[3]),
  .run0(run_q[0]), .flag0(flag_q[0]), .inc0(inc[0]), .ovf0(ovf[0]),
  .glvl0(gate_lvl[0]), .lo0(lo_w[0]), .hi0(hi_w[0]), .lo1(lo_w[1]), .hi1(hi_w[1])
);

// File: tb/dual_timer_core_test.sv
`timescale 1ns/1ps
module dual_timer_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [1:0] cnt_pin = 2'b11;
  logic [1:0] gate_pin = 2'b00;
  logic [1:0] irq_ack = 2'b00;
  logic [1:0] irq;

  always #2.5 clk = ~clk;

  dual_timer_core uut (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .cnt_pin_i(cnt_pin),
    .gate_pin_i(gate_pin), .irq_ack_i(irq_ack), .irq_o(irq)
  );

  int checks = 0;
  int fails = 0;
  bit cmp_on = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  int m_pc, m_lo[2], m_hi[2];
  bit m_r1, m_r2, m_s1[2], m_s2[2], m_s3[2], m_g1[2], m_g2[2], m_pend[2];
  bit m_run[2], m_flag[2];
  bit [7:0] m_mode;
  bit [3:0] m_cks;

  task automatic model_reset();
    m_pc = 0; m_mode = 0; m_cks = 0;
    for (int i = 0; i < 2; i++) begin
      m_lo[i] = 0; m_hi[i] = 0; m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0;
      m_g1[i] = 0; m_g2[i] = 0; m_pend[i] = 0; m_run[i] = 0; m_flag[i] = 0;
    end
  endtask

  task automatic model_step();
    bit tk[2], fl[2], inc[2], ov[2], hov, wc;
    int md[2], v;
    if (!rst_n) begin model_reset(); m_r1 = 0; m_r2 = 0; return; end
    if (!m_r2) begin m_r2 = m_r1; m_r1 = 1; return; end
    hov = 0;
    for (int i = 0; i < 2; i++) begin
      md[i] = (m_mode >> (4*i)) & 3;
      tk[i] = m_cks[2+i] ? 1'b1 : (m_cks[i] ? (m_pc % 4 == 3) : (m_pc == 11));
      fl[i] = m_s3[i] && !m_s2[i];
      inc[i] = m_run[i] && (!m_mode[4*i+3] || m_g2[i]) && tk[i] &&
               (!m_mode[4*i+2] || m_pend[i] || fl[i]);
      ov[i] = 0;
    end
    for (int i = 0; i < 2; i++) begin
      bit wl, wh;
      wl = bus_wr && bus_addr == 3 + 2*i;
      wh = bus_wr && bus_addr == 4 + 2*i;
      if (wl || wh) begin
        if (wl) m_lo[i] = bus_wdata;
        if (wh) m_hi[i] = bus_wdata;
      end else if (!(i == 1 && md[0] == 3)) begin
        case (md[i])
          0: if (inc[i]) begin
               if ((m_lo[i] & 31) == 31) begin
                 if (m_hi[i] == 255) ov[i] = 1;
                 m_hi[i] = (m_hi[i] + 1) & 255;
               end
               m_lo[i] = (m_lo[i] & 8'hE0) | ((m_lo[i] + 1) & 31);
             end
          1: if (inc[i]) begin
               v = m_hi[i] * 256 + m_lo[i];
               if (v == 65535) ov[i] = 1;
               v = (v + 1) & 65535;
               m_hi[i] = v / 256; m_lo[i] = v % 256;
             end
          2: if (inc[i]) begin
               if (m_lo[i] == 255) begin m_lo[i] = m_hi[i]; ov[i] = 1; end
               else m_lo[i] = m_lo[i] + 1;
             end
          default: if (i == 0) begin
               if (inc[0]) begin
                 if (m_lo[0] == 255) ov[0] = 1;
                 m_lo[0] = (m_lo[0] + 1) & 255;
               end
               if (m_run[1] && tk[0]) begin
                 if (m_hi[0] == 255) hov = 1;
                 m_hi[0] = (m_hi[0] + 1) & 255;
               end
             end
        endcase
      end
    end
    wc = bus_wr && bus_addr == 1;
    ov[1] = ov[1] | hov;
    for (int i = 0; i < 2; i++) begin
      m_flag[i] = ov[i] || (wc ? bus_wdata[5+2*i] : (m_flag[i] && !irq_ack[i]));
      m_run[i]  = wc ? bus_wdata[4+2*i] : m_run[i];
      m_pend[i] = (m_pend[i] || fl[i]) && !tk[i];
      m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = cnt_pin[i];
      m_g2[i] = m_g1[i]; m_g1[i] = gate_pin[i];
    end
    if (bus_wr && bus_addr == 0) m_mode = bus_wdata;
    if (bus_wr && bus_addr == 2) m_cks = bus_wdata[3:0];
    m_pc = (m_pc + 1) % 12;
  endtask

  function automatic bit [7:0] model_read(bit [2:0] a);
    case (a)
      0: return m_mode;
      1: return {m_flag[1], m_run[1], m_flag[0], m_run[0], 4'b0000};
      2: return {4'b0000, m_cks};
      3: return 8'(m_lo[0]);
      4: return 8'(m_hi[0]);
      5: return 8'(m_lo[1]);
      6: return 8'(m_hi[1]);
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) model_step();

  always @(negedge clk) if (cmp_on) begin
    chk({cur_req, " model rdata"}, bus_rdata, model_read(bus_addr));
    chk({cur_req, " model irq"}, {6'b0, irq}, {6'b0, m_flag[1], m_flag[0]});
  end

  task automatic wr(bit [2:0] a, bit [7:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic peek(bit [2:0] a, bit [7:0] e, string req);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    chk(req, bus_rdata, e);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // steps counted: n + 2 qualifying edges between start and stop writes
  task automatic run_for(bit [7:0] cv, int n, bit tog);
    wr(1, cv);
    repeat (n) begin
      @(posedge clk); #1;
      if (tog) cnt_pin[0] = ~cnt_pin[0];
    end
    wr(1, 8'h00);
  endtask

  task automatic ack0();
    @(posedge clk); #1; irq_ack[0] = 1'b1;
    @(posedge clk); #1; irq_ack[0] = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] got;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4);
    cmp_on = 1'b1;

    cur_req = "R1";
    for (int a = 0; a < 8; a++) peek(3'(a), 8'h00, "R1 reset value");
    chk("R1 irq after reset", {6'b0, irq}, 8'h00);

    cur_req = "R3";
    wr(0, 8'h00); wr(2, 8'h04); wr(4, 8'hFF); wr(3, 8'hFE);
    run_for(8'h10, 0, 0);
    peek(4, 8'h00, "R3 high byte wrapped");
    peek(3, 8'hE0, "R3 low bits 7:5 kept, 4:0 wrapped");
    peek(1, 8'h20, "R3 flag set (R9 set beats clear)");
    chk("R9 irq mirrors flag", {6'b0, irq}, 8'h01);
    cur_req = "R9";
    ack0();
    peek(1, 8'h00, "R9 ack clears flag");

    cur_req = "R2";
    wr(0, 8'h01); wr(4, 8'h12); wr(3, 8'hFF);
    run_for(8'h10, 0, 0);
    peek(4, 8'h13, "R2 16-bit carry high");
    peek(3, 8'h01, "R2 16-bit low");
    wr(4, 8'hFF); wr(3, 8'hFE);
    run_for(8'h10, 0, 0);
    peek(4, 8'h00, "R2 16-bit wrap high");
    peek(1, 8'h20, "R2 16-bit wrap flag");
    cur_req = "R9";
    wr(1, 8'h00);
    peek(1, 8'h00, "R9 write zero clears flag");

    cur_req = "R4";
    wr(0, 8'h02); wr(4, 8'hF0); wr(3, 8'hFE);
    run_for(8'h10, 0, 0);
    peek(3, 8'hF0, "R4 reload from high");
    peek(1, 8'h20, "R4 reload flag");
    run_for(8'h10, 1, 0);
    peek(3, 8'hF3, "R4 counting after reload");

    cur_req = "R5";
    wr(0, 8'h13); wr(5, 8'h40); wr(6, 8'h00); wr(4, 8'hFE); wr(3, 8'hFE);
    run_for(8'h50, 0, 0);
    peek(3, 8'h00, "R5 split low byte");
    peek(4, 8'h00, "R5 split high byte");
    peek(5, 8'h40, "R5 channel 1 held");
    peek(1, 8'hA0, "R5 both flags");
    chk("R5 both irq lines", {6'b0, irq}, 8'h03);
    wr(1, 8'h00);
    wr(0, 8'h10); wr(2, 8'h08);
    run_for(8'h40, 0, 0);
    peek(5, 8'h42, "R5 channel 1 runs when not split");

    cur_req = "R6";
    wr(2, 8'h04); wr(0, 8'h09); wr(3, 8'h00); wr(4, 8'h00);
    run_for(8'h10, 5, 0);
    peek(3, 8'h00, "R6 gate low blocks");
    gate_pin[0] = 1'b1;
    idle(4);
    run_for(8'h10, 0, 0);
    peek(3, 8'h02, "R6 gate high counts");
    wr(1, 8'h00);
    peek(3, 8'h02, "R6 run low holds");
    gate_pin[0] = 1'b0;

    cur_req = "R7";
    wr(0, 8'h05); wr(2, 8'h04); wr(3, 8'h00); wr(4, 8'h00);
    wr(1, 8'h10);
    repeat (3) begin
      @(posedge clk); #1 cnt_pin[0] = 1'b0;
      idle(3);
      @(posedge clk); #1 cnt_pin[0] = 1'b1;
      idle(3);
    end
    idle(6);
    wr(1, 8'h00);
    peek(3, 8'h03, "R7 three falling edges");
    wr(2, 8'h00); wr(3, 8'h00);
    run_for(8'h10, 118, 1);
    cnt_pin[0] = 1'b1;
    @(posedge clk); #1 bus_addr = 3'd3;
    @(negedge clk);
    got = bus_rdata;
    checks++;
    if (got > 8'd10 || got < 8'd9) begin
      fails++;
      $display("FAIL R7 once per tick actual=%02h expected=09..0a", got);
    end

    cur_req = "R8";
    wr(0, 8'h01); wr(2, 8'h00); wr(3, 8'h00); wr(4, 8'h00);
    run_for(8'h10, 118, 0);
    peek(3, 8'h0A, "R8 divide by 12");
    wr(2, 8'h01); wr(3, 8'h00);
    run_for(8'h10, 118, 0);
    peek(3, 8'h1E, "R8 divide by 4");
    wr(2, 8'h05); wr(3, 8'h00);
    run_for(8'h10, 8, 0);
    peek(3, 8'h0A, "R8 divide by 1 has priority");
    wr(0, 8'h10); wr(2, 8'h02); wr(5, 8'h00); wr(6, 8'h00);
    run_for(8'h40, 118, 0);
    peek(5, 8'h1E, "R8 channel 1 divide by 4");

    cur_req = "R10";
    wr(0, 8'h01); wr(2, 8'h04); wr(4, 8'h00); wr(3, 8'h00);
    wr(1, 8'h10); wr(3, 8'h55); wr(1, 8'h00);
    peek(3, 8'h57, "R10 write beats step");
    peek(4, 8'h00, "R10 high untouched");

    idle(4);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule